// File: doc/BRIEF.md
# BCD Seven-Segment Latching Display Decoder

This block turns a 4-bit binary-coded decimal digit into the seven drive lines of a numeric segment display. The digit passes through a code store that is transparent while `load_en_i` is high and holds its contents while it is low. An active-high blank input and any code above nine turn every segment off. A polarity input inverts all seven lines, blanks included, so the same block can drive common-cathode LEDs (polarity held low), common-anode LEDs (polarity held high) or liquid crystal segments, which need AC drive.

For liquid crystal panels, one square wave feeds both the polarity control and the panel's common plate. A lit segment then always sits in antiphase with the plate, and an unlit segment stays in phase with it. An internal divider can produce that wave from the system clock. `phase_sel_i` chooses between the internal wave and the external `phase_i` pin, and the wave also leaves the block on `backplane_o`. The segment lines and `backplane_o` are registered together, so all eight change on the same edge.

Top module: `bcd_seg_drv`

## Requirements
- R1: While `rst_ni` is low, `seg_o` and `backplane_o` are 0 and the stored code is 0. After release, with `load_en_i` low, `blank_i` low and polarity 0, the first edge shows digit 0 (`7'h3F`).
- R2: With polarity 0 and no blanking, codes 0 to 9 produce these `seg_o` values (bit 0 = segment a, top, then clockwise b, c, d, e, f, with bit 6 = g, middle): 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).
- R3: Codes 10 to 15 turn all seven segments off, exactly as blanking does.
- R4: When `blank_i` is 1, all segments are off whatever the code and `load_en_i` are.
- R5: When the selected polarity is 1, every bit of `seg_o` is the inverse of its polarity-0 value. Blanked and invalid codes then give `7'h7F`.
- R6: When `load_en_i` is 1, the store is transparent and `seg_o` follows `bcd_i`.
- R7: When `load_en_i` is 0, `seg_o` shows the code that was present at the last clock edge where `load_en_i` was 1. Changes on `bcd_i` have no effect.
- R8: A change of code, blank or polarity appears on `seg_o` exactly one clock later, with all seven bits switching on the same edge.
- R9: The internal polarity wave has 50% duty. It holds each level for `DIV_N/2` clock cycles and is visible on `backplane_o`.
- R10: When `phase_sel_i` is 1, the internal wave replaces `phase_i`. `backplane_o` is registered on the same edge as `seg_o`, so a lit segment equals `~backplane_o` and an unlit segment equals `backplane_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bcd_i | input | 4 | BCD digit, bit 3 most significant |
| load_en_i | input | 1 | 1: store transparent; 0: store holds |
| blank_i | input | 1 | 1: all segments off |
| phase_i | input | 1 | External polarity (0 common cathode, 1 common anode) |
| phase_sel_i | input | 1 | 1: use the internal square wave as polarity |
| seg_o | output | 7 | Segment lines, bit 0 = a through bit 6 = g |
| backplane_o | output | 1 | Registered internal square wave for the common plate |

## Verification
All sixteen codes are applied at both external polarities. The ten digit patterns tell the decode apart from the blank, and the six illegal codes confirm forced blanking, also in the inverted form. The blank input is then combined with valid digits, with illegal digits and with both polarities, to show that it overrides everything. With the store closed, the digit on `bcd_i` is changed to both valid and illegal values and the held digit must persist. In internal-polarity mode, the lengths of the runs on `backplane_o` and the segment-to-plate relation for a digit with only a few segments lit separate correct antiphase drive from a one-cycle skew.

// File: rtl/bcd_seg_pkg.sv
package bcd_seg_pkg;
  localparam int SEG_W = 7;
  localparam int CODE_W = 4;
  typedef logic [SEG_W-1:0] seg_t;
  typedef logic [CODE_W-1:0] code_t;

  // bit0 = a ... bit6 = g; codes above 9 are dark
  function automatic seg_t digit_pattern(code_t code);
    case (code)
      4'd0:    digit_pattern = 7'h3F;
      4'd1:    digit_pattern = 7'h06;
      4'd2:    digit_pattern = 7'h5B;
      4'd3:    digit_pattern = 7'h4F;
      4'd4:    digit_pattern = 7'h66;
      4'd5:    digit_pattern = 7'h6D;
      4'd6:    digit_pattern = 7'h7D;
      4'd7:    digit_pattern = 7'h07;
      4'd8:    digit_pattern = 7'h7F;
      4'd9:    digit_pattern = 7'h6F;
      default: digit_pattern = 7'h00;
    endcase
  endfunction
endpackage

// File: rtl/bcd_code_store.sv
module bcd_code_store
  import bcd_seg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  code_t code_i,
  input  logic  load_en_i,
  output code_t code_o
);
  code_t held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        held_q <= '0;
    else if (load_en_i) held_q <= code_i;
  end

  // transparent while open
  assign code_o = load_en_i ? code_i : held_q;
endmodule

// File: rtl/bcd_seg_decode.sv
module bcd_seg_decode
  import bcd_seg_pkg::*;
(
  input  code_t code_i,
  input  logic  blank_i,
  input  logic  phase_i,
  output seg_t  seg_o
);
  seg_t lit;

  always_comb begin
    lit   = blank_i ? '0 : digit_pattern(code_i);
    seg_o = lit ^ {SEG_W{phase_i}};
  end
endmodule

// File: rtl/bcd_phase_gen.sv
module bcd_phase_gen #(
  parameter int DIV_N = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic phase_o
);
  localparam int HALF = DIV_N / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/bcd_seg_drv.sv
module bcd_seg_drv
  import bcd_seg_pkg::*;
#(
  parameter int DIV_N = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] bcd_i,
  input  logic       load_en_i,
  input  logic       blank_i,
  input  logic       phase_i,
  input  logic       phase_sel_i,
  output logic [6:0] seg_o,
  output logic       backplane_o
);
  code_t code_eff;
  logic  ph_int;
  logic  ph_sel;
  seg_t  seg_d;
  seg_t  seg_q;
  logic  bp_q;

  bcd_code_store u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .code_i    (bcd_i),
    .load_en_i (load_en_i),
    .code_o    (code_eff)
  );

  bcd_phase_gen #(.DIV_N(DIV_N)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_o (ph_int)
  );

  assign ph_sel = phase_sel_i ? ph_int : phase_i;

  bcd_seg_decode u_dec (
    .code_i  (code_eff),
    .blank_i (blank_i),
    .phase_i (ph_sel),
    .seg_o   (seg_d)
  );

  // segments and plate share one register stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q <= '0;
      bp_q  <= 1'b0;
    end else begin
      seg_q <= seg_d;
      bp_q  <= ph_int;
    end
  end

  assign seg_o       = seg_q;
  assign backplane_o = bp_q;
endmodule

// File: rtl/bcd_seg_drv_chk.sv
module bcd_seg_drv_chk #(
  parameter int DIV_N = 8
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] bcd_i,
  input logic       load_en_i,
  input logic       blank_i,
  input logic       phase_i,
  input logic       phase_sel_i,
  input logic [6:0] seg_o,
  input logic       backplane_o
);
  localparam int HALF = DIV_N / 2;
  localparam int RW   = $clog2(DIV_N + 1) + 1;

  logic [1:0]    live_q;
  logic [RW-1:0] run_q;
  logic          seen_q;
  logic          bp_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q    <= '0;
      run_q     <= '0;
      seen_q    <= 1'b0;
      bp_prev_q <= 1'b0;
    end else begin
      live_q    <= {live_q[0], 1'b1};
      bp_prev_q <= backplane_o;
      if (backplane_o != bp_prev_q) begin
        run_q  <= '0;
        seen_q <= 1'b1;
      end else if (run_q != {RW{1'b1}}) begin
        run_q  <= run_q + 1'b1;
      end
    end
  end

  AST_RESET_DARK: assert property (@(posedge clk_i)
    !rst_ni |-> (seg_o == 7'h00 && !backplane_o)); // R1

  AST_BLANK_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_i && !phase_sel_i) |=> (seg_o == {7{$past(phase_i)}})); // R4

  AST_BAD_CODE_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_en_i && bcd_i > 4'd9 && !phase_sel_i) |=> (seg_o == {7{$past(phase_i)}})); // R3

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q[1] && !load_en_i && $stable(blank_i) && $stable(phase_i)
     && !phase_sel_i && $stable(phase_sel_i)) |=> $stable(seg_o)); // R7

  AST_PLATE_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_sel_i && blank_i) |=> (seg_o == {7{backplane_o}})); // R10

  AST_PLATE_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && backplane_o != bp_prev_q) |-> (run_q == RW'(HALF - 1))); // R9
endmodule

bind bcd_seg_drv bcd_seg_drv_chk #(.DIV_N(DIV_N)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bcd_i       (bcd_i),
  .load_en_i   (load_en_i),
  .blank_i     (blank_i),
  .phase_i     (phase_i),
  .phase_sel_i (phase_sel_i),
  .seg_o       (seg_o),
  .backplane_o (backplane_o)
);

// File: tb/tb_bcd_seg_drv.sv
module tb_bcd_seg_drv;
  localparam int DIV_N = 8;
  localparam int HALF  = DIV_N / 2;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] bcd_i = '0;
  logic       load_en_i = 1'b0;
  logic       blank_i = 1'b0;
  logic       phase_i = 1'b0;
  logic       phase_sel_i = 1'b0;
  logic [6:0] seg_o;
  logic       backplane_o;

  int total = 0;
  int bad = 0;

  bcd_seg_drv #(.DIV_N(DIV_N)) dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bcd_i       (bcd_i),
    .load_en_i   (load_en_i),
    .blank_i     (blank_i),
    .phase_i     (phase_i),
    .phase_sel_i (phase_sel_i),
    .seg_o       (seg_o),
    .backplane_o (backplane_o)
  );

  always #4 clk_i = ~clk_i;

  function automatic logic [6:0] exp_seg(int code, bit blank, bit ph);
    logic [6:0] p;
    case (code)
      0: p = 7'b0111111;
      1: p = 7'b0000110;
      2: p = 7'b1011011;
      3: p = 7'b1001111;
      4: p = 7'b1100110;
      5: p = 7'b1101101;
      6: p = 7'b1111101;
      7: p = 7'b0000111;
      8: p = 7'b1111111;
      9: p = 7'b1101111;
      default: p = 7'b0000000;
    endcase
    if (blank) p = 7'b0000000;
    return ph ? ~p : p;
  endfunction

  task automatic chk(string req, logic [6:0] got, logic [6:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    #1;
    chk("R1 seg in reset", seg_o, 7'h00);
    chk("R1 plate in reset", {6'b0, backplane_o}, 7'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    load_en_i = 1'b0;
    bcd_i = 4'd7;
    step();
    chk("R1 stored code zero", seg_o, exp_seg(0, 0, 0));
  endtask

  task automatic t_codes(bit ph);
    phase_i = ph;
    load_en_i = 1'b1;
    blank_i = 1'b0;
    for (int c = 0; c < 16; c++) begin
      bcd_i = 4'(c);
      step();
      if (c < 10) chk(ph ? "R5 R2 R6 digit" : "R2 R6 digit", seg_o, exp_seg(c, 0, ph));
      else        chk(ph ? "R5 R3 bad code" : "R3 bad code", seg_o, exp_seg(c, 0, ph));
    end
  endtask

  task automatic t_blank();
    load_en_i = 1'b1;
    blank_i = 1'b1;
    for (int ph = 0; ph < 2; ph++) begin
      phase_i = ph[0];
      bcd_i = 4'd8;
      step();
      chk("R4 blank digit", seg_o, ph[0] ? 7'h7F : 7'h00);
      bcd_i = 4'd13;
      step();
      chk("R4 blank bad code", seg_o, ph[0] ? 7'h7F : 7'h00);
    end
    load_en_i = 1'b0;
    phase_i = 1'b0;
    bcd_i = 4'd2;
    step();
    chk("R4 blank while holding", seg_o, 7'h00);
    blank_i = 1'b0;
    step();
    chk("R4 unblank shows held", seg_o, exp_seg(13, 0, 0));
  endtask

  task automatic t_hold();
    phase_i = 1'b0;
    blank_i = 1'b0;
    load_en_i = 1'b1;
    bcd_i = 4'd5;
    step();
    chk("R6 load five", seg_o, exp_seg(5, 0, 0));
    load_en_i = 1'b0;
    bcd_i = 4'd3;
    step();
    chk("R7 hold vs 3", seg_o, exp_seg(5, 0, 0));
    bcd_i = 4'd12;
    step();
    chk("R7 hold vs 12", seg_o, exp_seg(5, 0, 0));
    phase_i = 1'b1;
    step();
    chk("R7 R5 held inverted", seg_o, exp_seg(5, 0, 1));
    phase_i = 1'b0;
    load_en_i = 1'b1;
    bcd_i = 4'd4;
    @(posedge clk_i);
    #1;
    load_en_i = 1'b0;
    bcd_i = 4'd9;
    @(negedge clk_i);
    chk("R8 one edge latency", seg_o, exp_seg(4, 0, 0));
    step();
    chk("R7 captured at last open edge", seg_o, exp_seg(4, 0, 0));
  endtask

  task automatic t_phase_gen();
    logic prev;
    int   run;
    int   toggles;
    phase_sel_i = 1'b1;
    phase_i = 1'b0;
    blank_i = 1'b0;
    load_en_i = 1'b1;
    bcd_i = 4'd1;
    step();
    prev = backplane_o;
    run = 0;
    toggles = 0;
    for (int i = 0; i < 8 * DIV_N; i++) begin
      step();
      chk("R10 antiphase digit 1", seg_o,
          {{4{backplane_o}}, ~backplane_o, ~backplane_o, backplane_o});
      if (backplane_o != prev) begin
        if (toggles > 0) chk("R9 half period", 7'(run), 7'(HALF));
        toggles++;
        run = 1;
      end else begin
        run++;
      end
      prev = backplane_o;
    end
    chk("R9 plate toggles", 7'(toggles > 6), 7'd1);
    phase_sel_i = 1'b0;
    phase_i = 1'b1;
    step();
    chk("R10 external polarity restored", seg_o, exp_seg(1, 0, 1));
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_codes(1'b0);
        t_codes(1'b1);
        t_blank();
        t_hold();
        t_phase_gen();
      end
      begin
        repeat (100000) @(posedge clk_i);
        total++;
        bad++;
        $display("FAIL watchdog got=hang exp=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule